// File: doc/BRIEF.md
# Host/BMC Byte Mailbox Register Block

This block gives a host processor and a management controller a pair of one-byte mailboxes with a shared status byte. The host deposits a byte that the management side collects, and the management side deposits a byte that the host collects. Each mailbox has a full flag. Writing the mailbox sets the flag and raises an interrupt level toward the reader. The reader's data read clears the flag, and that read also serves as the acknowledge.

The status byte mixes three kinds of bits. The full flags and a command/data marker are kept by hardware. The remaining bits are free for software, and only the management side can change them. Changing those bits never raises an interrupt by itself: software that wants the host to notice a status change has to follow it with a write to the outbound mailbox. Each side uses a plain synchronous write strobe, read strobe and one-bit register select. Bus cycle decoding and interrupt serialisation are done outside this block.

Top module: `hostbmc_mailbox`

## Requirements
- R1: After reset both mailbox bytes read 0x00, the status byte reads 0x00, and both interrupt outputs are low.
- R2: A host write with `h_sel`=0 or 1 stores `h_wdata` in the inbound mailbox and sets status bit 1 (inbound full) from the next cycle. The stored byte is then visible on `b_rdata` when `b_sel`=0.
- R3: A management read with `b_rd`=1 and `b_sel`=0 clears status bit 1 from the next cycle and leaves the byte in place. A management read with `b_sel`=1 (status) changes nothing.
- R4: A management write with `b_sel`=0 stores `b_wdata` in the outbound mailbox and sets status bit 0 (outbound full) from the next cycle. The byte is then visible on `h_rdata` when `h_sel`=0.
- R5: A host read with `h_rd`=1 and `h_sel`=0 clears status bit 0 from the next cycle. A host read with `h_sel`=1 (status) changes nothing.
- R6: Status bit 3 becomes 1 after a host write with `h_sel`=1 (command) and becomes 0 after a host write with `h_sel`=0 (data). It keeps its value otherwise.
- R7: A management write with `b_sel`=1 loads bits 7, 6, 5, 4 and 2 of the status byte from `b_wdata`. It leaves bits 3, 1 and 0 unchanged and never raises `h_irq`.
- R8: No host access changes status bits 7, 6, 5, 4 or 2.
- R9: A host write while the inbound mailbox is already full replaces the stored byte, and status bit 1 stays 1.
- R10: When a write and the clearing read of the same mailbox happen in the same cycle, the write wins: the new byte is stored and the full flag stays 1.
- R11: `b_irq` equals status bit 1 and `h_irq` equals status bit 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_sel | input | 1 | Host select: 0 data, 1 command write / status read |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte: outbound mailbox or status |
| h_irq | output | 1 | Host interrupt level, high while outbound mailbox full |
| b_wr | input | 1 | Management write strobe |
| b_rd | input | 1 | Management read strobe |
| b_sel | input | 1 | Management select: 0 data, 1 status |
| b_wdata | input | 8 | Management write byte |
| b_rdata | output | 8 | Management read byte: inbound mailbox or status |
| b_irq | output | 1 | Management interrupt level, high while inbound mailbox full |

## Verification
The mailbox function is driven with single writes, writes made while a mailbox is already full, and writes paired in the same cycle with the clearing read. These patterns separate the set, clear, overwrite and collision priorities of each full flag. Status writes are tried with all-ones and sparse patterns, so a mask that leaks into a hardware bit or drops a software bit shows up as a wrong status byte. Host accesses are made with the software bits set, which shows whether the host side can disturb them. Strobe-free views of each register are taken after every step, so that a read with a side effect on the wrong address is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_W  = 8;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;
  localparam logic [STAT_W-1:0] SW_MASK = 8'hF4;

  function automatic logic [STAT_W-1:0] sw_load(input logic [STAT_W-1:0] wval);
    return wval & SW_MASK;
  endfunction

  function automatic logic [STAT_W-1:0] compose_status(
    input logic [STAT_W-1:0] sw_bits,
    input logic              cd,
    input logic              ibf,
    input logic              obf
  );
    logic [STAT_W-1:0] s;
    s          = sw_bits & SW_MASK;
    s[CD_BIT]  = cd;
    s[IBF_BIT] = ibf;
    s[OBF_BIT] = obf;
    return s;
  endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          full
);
  logic fill_evt;
  logic drain_evt;

  assign fill_evt  = wr;
  assign drain_evt = rd && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (fill_evt) begin
        data <= wdata;
        full <= 1'b1;
      end else if (drain_evt) begin
        full <= 1'b0;
      end
    end
  end

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> full); // R2, R4, R10
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt |=> !full); // R3, R5
  AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> data == $past(wdata)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !rd) |=> $stable(full) && $stable(data)); // R3
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              cd_wr,
  input  logic              cd_val,
  input  logic              ibf,
  input  logic              obf,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] sw_q;
  logic              cd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= '0;
      cd_q <= 1'b0;
    end else begin
      if (sw_wr) sw_q <= sw_load(sw_wdata);
      if (cd_wr) cd_q <= cd_val;
    end
  end

  assign stat = compose_status(sw_q, cd_q, ibf, obf);

  AST_SW_ONLY_BMC: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (stat & SW_MASK) == ($past(stat) & SW_MASK)); // R8
  AST_CD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cd_wr |=> stat[CD_BIT] == $past(cd_val)); // R6
  AST_CD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cd_wr |=> $stable(stat[CD_BIT])); // R6
endmodule

// File: rtl/hostbmc_mailbox.sv
module hostbmc_mailbox
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic          h_sel,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic          b_sel,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int SW = (DW < STAT_W) ? DW : STAT_W;

  logic [DW-1:0]     in_data;
  logic [DW-1:0]     out_data;
  logic              in_full;
  logic              out_full;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] status_wval;
  logic [DW-1:0]     status_view;

  // named access events
  logic host_fill;
  logic bmc_drain;
  logic bmc_fill;
  logic host_drain;
  logic stat_write;

  assign host_fill  = h_wr;
  assign bmc_drain  = b_rd && !b_sel;
  assign bmc_fill   = b_wr && !b_sel;
  assign host_drain = h_rd && !h_sel;
  assign stat_write = b_wr && b_sel;

  always_comb begin
    status_wval         = '0;
    status_wval[SW-1:0] = b_wdata[SW-1:0];
    status_view         = '0;
    status_view[SW-1:0] = status[SW-1:0];
  end

  mbx_slot #(.DW(DW)) u_inbound (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (host_fill),
    .rd    (bmc_drain),
    .wdata (h_wdata),
    .data  (in_data),
    .full  (in_full)
  );

  mbx_slot #(.DW(DW)) u_outbound (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bmc_fill),
    .rd    (host_drain),
    .wdata (b_wdata),
    .data  (out_data),
    .full  (out_full)
  );

  mbx_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (stat_write),
    .sw_wdata (status_wval),
    .cd_wr    (host_fill),
    .cd_val   (h_sel),
    .ibf      (in_full),
    .obf      (out_full),
    .stat     (status)
  );

  assign h_rdata = h_sel ? status_view : out_data;
  assign b_rdata = b_sel ? status_view : in_data;
  assign h_irq   = out_full;
  assign b_irq   = in_full;

  AST_BIRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_irq) |-> $past(h_wr)); // R2
  AST_HIRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_irq) |-> $past(b_wr && !b_sel)); // R7
  AST_STATUS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_write && !h_rd) |=> h_irq == $past(h_irq)); // R7
  AST_IRQ_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (b_irq == status[IBF_BIT]) && (h_irq == status[OBF_BIT])); // R11
endmodule

// File: tb/hostbmc_mailbox_test.sv
module hostbmc_mailbox_test;
  localparam int PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic hw, hr, hs, bw, br, bs;
    logic [7:0] hd, bd, st, idr, odr;
  } vec_t;

  // fields: hw hr hs bw br bs | hd bd | expected status, inbound, outbound
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h11,8'h00, 8'h02,8'h11,8'h00}, // R2
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00, 8'h0A,8'h00,8'h00}, // R9, R6
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,8'h00, 8'h08,8'h00,8'h00}, // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00,8'hC4, 8'hCC,8'h00,8'h00}, // R7
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00,8'hFF, 8'hFC,8'h00,8'h00}, // R7
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'hA5, 8'hFD,8'h00,8'hA5}, // R4
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h01,8'h00, 8'hFF,8'h01,8'hA5}, // R8
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00, 8'hFE,8'h01,8'hA5}, // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h5A, 8'hFF,8'h01,8'h5A}, // R10
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h33,8'h00, 8'hF7,8'h33,8'h5A}, // R10
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h00,8'h00, 8'h03,8'h33,8'h5A}, // R7
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 8'h00,8'h00, 8'h00,8'h33,8'h5A}, // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h77, 8'h01,8'h33,8'h77}, // R4
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00, 8'h01,8'h33,8'h77}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,8'h00, 8'h01,8'h33,8'h77}  // R3
  };
  localparam string TAGS [NV] = '{"R2","R9","R3","R7","R7","R4","R8",
                                  "R5","R10","R10","R7","R3","R4","R5","R3"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_wr = 1'b0, h_rd = 1'b0, h_sel = 1'b0;
  logic       b_wr = 1'b0, b_rd = 1'b0, b_sel = 1'b0;
  logic [7:0] h_wdata = '0, b_wdata = '0;
  logic [7:0] h_rdata, b_rdata;
  logic       h_irq, b_irq;
  int         checks = 0;
  int         errors = 0;

  always #(PERIOD/2) clk = ~clk;

  hostbmc_mailbox #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_sel(h_sel), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_sel(b_sel), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // strobe-free views of every register, taken mid-cycle
  task automatic observe(input string tag, input logic [7:0] st,
                         input logic [7:0] idr, input logic [7:0] odr);
    h_wr = 0; h_rd = 0; b_wr = 0; b_rd = 0;
    b_sel = 1; h_sel = 1; #1;
    check(tag, "status(bmc view)", b_rdata, st);
    check(tag, "status(host view)", h_rdata, st);
    check("R11", "b_irq", {7'b0, b_irq}, {7'b0, st[1]});
    check("R11", "h_irq", {7'b0, h_irq}, {7'b0, st[0]});
    b_sel = 0; h_sel = 0; #1;
    check(tag, "inbound byte", b_rdata, idr);
    check(tag, "outbound byte", h_rdata, odr);
  endtask

  initial begin
    #(PERIOD*5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    observe("R1", 8'h00, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      h_wr = VECS[i].hw; h_rd = VECS[i].hr; h_sel = VECS[i].hs; h_wdata = VECS[i].hd;
      b_wr = VECS[i].bw; b_rd = VECS[i].br; b_sel = VECS[i].bs; b_wdata = VECS[i].bd;
      @(posedge clk); #1;
      observe(TAGS[i], VECS[i].st, VECS[i].idr, VECS[i].odr);
    end

    // R8: host status read with software bits set leaves them alone
    @(negedge clk); b_wr = 1; b_sel = 1; b_wdata = 8'hB0;
    @(posedge clk); #1;
    @(negedge clk); h_rd = 1; h_sel = 1; h_wr = 0;
    @(posedge clk); #1;
    observe("R8", 8'hB1, 8'h33, 8'h77);

    // R1: reset mid-run clears everything
    @(negedge clk); h_wr = 1; h_sel = 1; h_wdata = 8'h99;
    @(posedge clk); #1;
    h_wr = 0; rst_n = 0;
    @(posedge clk); #1;
    observe("R1", 8'h00, 8'h00, 8'h00);
    @(negedge clk); rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule